// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Wiper Register

This block is the serial control port of a digital potentiometer. It watches a two-wire bus (a clock line and a bidirectional data line, both open drain), oversampled by a much faster system clock. It answers one 7-bit address: a fixed five-bit prefix followed by two bits taken from strap pins. Through that address a bus master can write an 8-bit wiper setting or read the current one back.

A write carries three bytes: the address byte, an instruction byte and a data byte. The slave acknowledges each of the three. The wiper register takes the new value only at the end of the acknowledge clock of the data byte. A read returns the wiper value, most significant bit first. The value is repeated for as long as the master keeps acknowledging.

The data line is driven only through an open-drain enable. The clock line is an input only; this block never stretches the clock. The wiper register is a plain output, and no stream handshake applies to it.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset the wiper output is 8'h80 and sda_oe is 0.
- R2: Until a START is seen (data line falling while the clock line is high), clocked bits are ignored. The slave never acknowledges them, and they never change the wiper.
- R3: An address byte whose bits 7..3 are 01011 and whose bits 2..1 equal strap_i[1:0] is acknowledged. The slave drives sda_oe=1 for the ninth clock. Bit 0 of the address byte selects the operation: 1 is a read and 0 is a write.
- R4: An address byte that does not match gets no acknowledge. Any later bytes in the same transfer also get no acknowledge and leave the wiper unchanged.
- R5: In a matched write, the instruction byte and the data byte are each acknowledged. After the ninth clock of the data byte, the wiper equals the data byte.
- R6: When bit 6 of the instruction byte is 1, the write sets the wiper to 8'h80 and the data byte is ignored.
- R7: A STOP (data line rising while the clock line is high) before the data byte is complete leaves the wiper unchanged.
- R8: In a matched read, the slave sends the wiper MSB first and releases the data line for the ninth clock. If the master acknowledges, the wiper is sent again. After a not-acknowledge, sda_oe stays 0.
- R9: A repeated START at any bit position restarts address reception. The transfer that follows behaves as a fresh one.
- R10: sda_oe changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| strap_i | input | 2 | Strapped low address bits |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper_o | output | 8 | Current wiper setting |

## Verification
The hardest states to reach from the ports are the interrupted transfers. These are a STOP or a repeated START that lands part way through a byte, after some bits have been shifted but before the byte's acknowledge. In a normal transfer, the bit counter and the pending data are never left half filled. The bench's master tasks can stop after any number of bits and then issue a STOP or a START. Directed cases use this to cut off the data byte and the address byte. Random transactions then vary the strap pins, the addresses, the instruction bit and the read lengths.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } eng_state_e;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic line_p
);
  logic [STAGES-1:0] chain;

  // Bus idles high, so the chain resets high to avoid false edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      line_p <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], line_i};
      line_p <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bus_cond.sv
module i2cw_bus_cond (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start,
  output logic stop
);
  // Any data-line edge while the clock is held high is a bus condition.
  always_comb begin
    scl_rise = scl_s & ~scl_p;
    scl_fall = ~scl_s & scl_p;
    start    = scl_s & scl_p & sda_p & ~sda_s;
    stop     = scl_s & scl_p & ~sda_p & sda_s;
  end
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int          PREFIX_W      = 5,
  parameter logic [4:0]  PREFIX        = 5'b01011,
  parameter int          STRAP_W       = 2,
  parameter logic [7:0]  MID_SCALE     = 8'h80,
  parameter int          INSTR_RST_BIT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start,
  input  logic               stop,
  input  logic [STRAP_W-1:0] strap,
  output logic               oe,
  output logic [7:0]         wiper
);
  localparam int BYTE_W = PREFIX_W + STRAP_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] pend;
  logic              rnw;
  logic              force_mid;
  logic              ack_seen;
  logic              addr_hit;

  assign addr_hit = (shreg[BYTE_W-1 -: PREFIX_W] == PREFIX[PREFIX_W-1:0]) &&
                    (shreg[STRAP_W:1] == strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      pend      <= '0;
      rnw       <= 1'b0;
      force_mid <= 1'b0;
      ack_seen  <= 1'b0;
      oe        <= 1'b0;
      wiper     <= MID_SCALE;
    end else if (start) begin
      st  <= ST_ADDR;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (stop) begin
      st  <= ST_IDLE;
      cnt <= '0;
      oe  <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                oe  <= 1'b1;
                rnw <= shreg[0];
                st  <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_INSTR) begin
              oe        <= 1'b1;
              force_mid <= shreg[INSTR_RST_BIT];
              st        <= ST_INSTR_ACK;
            end else begin
              oe   <= 1'b1;
              pend <= shreg;
              st   <= ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rnw) begin
            tx <= wiper;
            oe <= ~wiper[BYTE_W-1];
            st <= ST_RD_BYTE;
          end else begin
            oe <= 1'b0;
            st <= ST_INSTR;
          end
        end
        ST_INSTR_ACK: if (scl_fall) begin
          oe <= 1'b0;
          st <= ST_DATA;
        end
        ST_DATA_ACK: if (scl_fall) begin
          oe    <= 1'b0;
          wiper <= force_mid ? MID_SCALE : pend;
          st    <= ST_IDLE;
        end
        ST_RD_BYTE: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              oe  <= 1'b0;
              cnt <= '0;
              st  <= ST_RD_ACK;
            end else begin
              tx <= tx << 1;
              oe <= ~tx[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_seen <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_seen) begin
              tx <= wiper;
              oe <= ~wiper[BYTE_W-1];
              st <= ST_RD_BYTE;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: the enable moves only with the clock line low, bus conditions aside
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) && !$past(start) && !$past(stop) |-> !$past(scl_s));

  // R2: nothing is driven while waiting for a START
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe);

  // R7: the wiper moves only at the close of the data acknowledge
  p_wiper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper != $past(wiper)) |-> ($past(st) == ST_DATA_ACK && $past(scl_fall)));

  // R4: a mismatched address drops the slave back to idle, line released
  p_nomatch_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && scl_fall && cnt == CNT_FULL && !addr_hit && !start && !stop)
    |=> (st == ST_IDLE && !oe));

  // R9: a START always restarts address reception from bit zero
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == ST_ADDR && cnt == '0));

  // R3: the bit counter never runs past one byte
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe,
  output logic [7:0] wiper_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] synced;
  logic [N_LINES-1:0] prev;
  logic scl_rise, scl_fall, start, stop;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2cw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[g]),
      .line_s (synced[g]),
      .line_p (prev[g])
    );
  end

  i2cw_bus_cond u_cond (
    .scl_s    (synced[1]),
    .scl_p    (prev[1]),
    .sda_s    (synced[0]),
    .sda_p    (prev[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start    (start),
    .stop     (stop)
  );

  i2cw_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (synced[1]),
    .sda_s    (synced[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start    (start),
    .stop     (stop),
    .strap    (strap_i),
    .oe       (sda_oe),
    .wiper    (wiper_o)
  );
endmodule

// File: tb/sim_i2c_wiper_slave.sv
module sim_i2c_wiper_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 16;
  localparam int WATCHDOG   = 190000;
  localparam int N_RAND     = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe;
  logic [7:0] wiper;
  logic       sda_bus;

  int checks = 0;
  int fails  = 0;
  int r10_viol = 0;
  logic oe_q = 1'b0;
  logic [7:0] model_w;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_wiper_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe(sda_oe), .wiper_o(wiper)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_q && scl_m) r10_viol++;
    oe_q <= sda_oe;
  end

  function automatic logic f_match(input logic [6:0] a, input logic [1:0] s);
    return (a[6:2] == 5'b01011) && (a[1:0] == s);
  endfunction

  function automatic logic [7:0] f_next(input logic [7:0] ins, input logic [7:0] d);
    return ins[6] ? 8'h80 : d;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic bit_io(input logic b, output logic o);
    sda_m = b; qw(); scl_m = 1'b1; qw(); o = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic tx_byte(input logic [7:0] d, output logic acked);
    logic o;
    for (int i = 7; i >= 0; i--) bit_io(d[i], o);
    bit_io(1'b1, o);
    acked = ~o;
  endtask

  task automatic rx_byte(input logic ack, output logic [7:0] d);
    logic o;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, o);
      d = {d[6:0], o};
    end
    bit_io(~ack, o);
  endtask

  task automatic tx_bits(input logic [7:0] d, input int n);
    logic o;
    for (int i = 0; i < n; i++) bit_io(d[7-i], o);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] ins, input logic [7:0] d,
                          input string req);
    logic a0, a1, a2, m;
    m = f_match(a, strap);
    bus_start();
    tx_byte({a, 1'b0}, a0);
    tx_byte(ins, a1);
    tx_byte(d, a2);
    bus_stop();
    if (m) model_w = f_next(ins, d);
    chk({req, " addr ack"}, a0, m);
    chk({req, " instr ack"}, a1, m);
    chk({req, " data ack"}, a2, m);
    chk({req, " wiper"}, wiper, model_w);
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string req);
    logic a0;
    logic [7:0] d;
    bus_start();
    tx_byte({a, 1'b1}, a0);
    chk({req, " read addr ack"}, a0, f_match(a, strap));
    if (a0) begin
      for (int i = 0; i < n; i++) begin
        rx_byte(i != n - 1, d);
        chk({req, " read data"}, d, model_w);
      end
      chk({req, " released after nack"}, sda_oe, 0);
    end
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic o;
    logic [6:0] good;
    void'($urandom(32'd2024));
    model_w = 8'h80;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset wiper", wiper, 8'h80);
    chk("R1 reset sda_oe", sda_oe, 0);

    // R2: bytes clocked with no START first
    scl_m = 1'b0; qw();
    tx_byte({5'b01011, strap, 1'b0}, o);
    chk("R2 no ack without start", o, 0);
    tx_byte(8'h00, o);
    tx_byte(8'h33, o);
    chk("R2 no data ack without start", o, 0);
    bus_stop();
    chk("R2 wiper untouched", wiper, 8'h80);

    good = {5'b01011, strap};
    do_write(good, 8'h00, 8'h5A, "R3 R5 write");
    do_read(good, 3, "R8");
    do_write(good, 8'h40, 8'h11, "R6 midscale");
    do_write(good, 8'h00, 8'h22, "R5 write2");

    // R7: STOP half way through the data byte
    bus_start();
    tx_byte({good, 1'b0}, o);
    tx_byte(8'h00, o);
    tx_bits(8'hF0, 4);
    bus_stop();
    chk("R7 wiper after early stop", wiper, model_w);

    // R9: repeated START inside the data byte, then a full write
    bus_start();
    tx_byte({good, 1'b0}, o);
    tx_byte(8'h00, o);
    tx_bits(8'h0F, 3);
    chk("R9 no change before restart", wiper, model_w);
    do_write(good, 8'h00, 8'h77, "R9 restart write");
    // R9: repeated START inside the address byte, then a read
    bus_start();
    tx_bits({good, 1'b0}, 4);
    do_read(good, 1, "R9 restart read");

    do_write({5'b01011, ~strap}, 8'h00, 8'h99, "R4 strap mismatch");
    do_write({5'b11011, strap}, 8'h00, 8'h99, "R4 prefix mismatch");

    for (int k = 0; k < N_RAND; k++) begin
      logic [6:0] a;
      logic [7:0] ins, d;
      strap = 2'($urandom);
      a   = ($urandom % 2) ? {5'b01011, strap} : 7'($urandom);
      ins = 8'($urandom);
      d   = 8'($urandom);
      if ($urandom % 3 == 0) do_read(a, 1 + ($urandom % 3), "R8 R4 random read");
      else do_write(a, ins, d, "R3 R5 R6 random write");
    end

    chk("R10 sda_oe moved while clock high", r10_viol, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule